// File: doc/BRIEF.md
# Flash Command Sequencer with Boot-Region Write Lock

This block sits between a byte-wide parallel flash bus (chip enable, output enable and write enable, all active low) and a small synthesizable storage array. The bus strobes are sampled on the system clock. A write completes on the rising edge of the write enable while chip enable is low. Multi-cycle write sequences are decoded into array read, identification read, word program, chip erase and boot-lock enable. Any other write pattern leaves the contents untouched.

Addresses 0x0000 to 0x1FFF form a boot region. Once the sticky lock is set, program and erase cannot alter it unless the high-voltage override input is held. A device reset pin aborts operations and floats the bus. The chip erase is internally timed: it walks the array one word per cycle, raises a busy flag, and answers reads with a toggling status byte.

The storage model keeps 2^(IDX_W-1) words for the boot region and the same number for the rest. Inside each region, addresses alias on their low IDX_W-1 bits.

Top module: `flash_cmd_seq`

## Requirements
- R1: `data_oe_o` is high only while `ce_ni`, `oe_ni` are both low, `dev_rst_ni` is high and no reset recovery is pending; otherwise the bus is released.
- R2: After `rst_ni` every location reads 0xFF in array mode, the lock is clear and `busy_o` is low.
- R3: Writes AA@5555, 55@2AAA, A0@5555 followed by a write of D to address A set location A to old AND D.
- R4: Writes AA@5555, 55@2AAA, 90@5555 enter identification mode: address 0x0000 reads 0xDA, 0x0001 reads 0x8C, 0x0002 reads the lock state in bit 0 with the other bits zero, and any other address reads 0x00.
- R5: Identification mode is left by AA@5555, 55@2AAA, F0@5555, or by one write of 0xF0 to any address.
- R6: A write that does not match the next expected cycle of a sequence returns to array read, and no location changes.
- R7: Writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 start a chip erase. `busy_o` is then high for exactly ERASE_CYC cycles, and afterwards every unprotected location reads 0xFF.
- R8: While `busy_o` is high, writes are ignored and reads return a status byte whose bit 6 flips on each new read access, with all other bits zero.
- R9: The same six cycles ending in 40@5555 set the lock. It stays set until `rst_ni`.
- R10: With the lock set and the override low, program and erase leave 0x0000 to 0x1FFF unchanged, while addresses above it still change.
- R11: While `hv_override_i` is high, the boot region can be programmed and erased. Protection resumes as soon as it drops, and the lock bit stays 1.
- R12: While `dev_rst_ni` is low the bus is released and writes are ignored. A low pulse of at least TRP_CYC cycles aborts an erase and returns to array read; a shorter one changes no mode.
- R13: After a qualifying device reset, reads stay blocked for TRH_CYC cycles after `dev_rst_ni` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| dev_rst_ni | input | 1 | Device reset pin, active low, sampled |
| hv_override_i | input | 1 | High-voltage override on the reset pin, suspends the lock |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low; a write completes on its rising edge |
| addr_i | input | ADDR_W | Word address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Drive enable of the tri-state data bus |
| busy_o | output | 1 | Chip erase in progress |

## Verification
The bench goes after the following corner cases:
- **Program before and after a lock.** A design that ignored the lock would overwrite boot bytes. One that checked protection against the wrong bound would freeze ordinary addresses as well.
- **An erase with the lock set.** A broken walker would wipe the boot region or leave stale bytes.
- **Broken and aborted sequences.** A sequencer that did not fall back would accept a later stray data write as a program.
- **Commands sent during busy.** A design that did not ignore them would come out of the erase in identification mode.
- **Reset pulses on either side of TRP_CYC and the TRH_CYC recovery window.** Each is checked to the cycle, so an off-by-one counter either lets a short glitch cancel identification mode or opens the bus one cycle early.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [15:0] UNL_ADDR_A = 16'h5555;
  localparam logic [15:0] UNL_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  UNL_DATA_A = 8'hAA;
  localparam logic [7:0]  UNL_DATA_B = 8'h55;
  localparam logic [7:0]  OP_ERASE_SETUP = 8'h80;
  localparam logic [7:0]  OP_CHIP_ERASE  = 8'h10;
  localparam logic [7:0]  OP_PROGRAM     = 8'hA0;
  localparam logic [7:0]  OP_ID_ENTER    = 8'h90;
  localparam logic [7:0]  OP_ID_EXIT     = 8'hF0;
  localparam logic [7:0]  OP_LOCK        = 8'h40;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ERS3, SQ_ERS4, SQ_ERS5
  } seq_st_e;
endpackage

// File: rtl/flash_bus_if.sv
module flash_bus_if #(
  parameter int TRP_CYC = 4,
  parameter int TRH_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic wr_stb_o,
  output logic rd_start_o,
  output logic hard_rst_o,
  output logic rd_ok_o
);
  localparam int LW = $clog2(TRP_CYC + 1);
  localparam int RW = $clog2(TRH_CYC + 1);

  logic          we_q;
  logic          idle_q;
  logic [LW-1:0] low_cnt_q;
  logic [RW-1:0] rec_q;

  assign wr_stb_o   = dev_rst_ni & we_ni & ~we_q & ~ce_ni;
  assign rd_start_o = dev_rst_ni & ~ce_ni & ~oe_ni & idle_q;
  assign hard_rst_o = ~dev_rst_ni & (low_cnt_q == LW'(TRP_CYC - 1));
  assign rd_ok_o    = dev_rst_ni & (rec_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q      <= 1'b1;
      idle_q    <= 1'b1;
      low_cnt_q <= '0;
      rec_q     <= '0;
    end else begin
      we_q   <= we_ni;
      idle_q <= ce_ni | oe_ni;
      if (dev_rst_ni) begin
        low_cnt_q <= '0;
        if (rec_q != '0) rec_q <= rec_q - 1'b1;
      end else begin
        if (low_cnt_q != LW'(TRP_CYC)) low_cnt_q <= low_cnt_q + 1'b1;
        // qualifying pulse arms the recovery window
        if (hard_rst_o || low_cnt_q == LW'(TRP_CYC)) rec_q <= RW'(TRH_CYC);
      end
    end
  end

  // R12
  single_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_o |=> !hard_rst_o);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic              busy_i,
  input  logic              hard_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              id_mode_o,
  output logic              prog_o,
  output logic              erase_o,
  output logic              lock_o
);
  seq_st_e st_q;
  logic    id_q;
  logic    take, hit_a, hit_b, at_a;

  assign take  = wr_stb_i & ~busy_i;
  assign at_a  = addr_i == ADDR_W'(UNL_ADDR_A);
  assign hit_a = at_a & (data_i == UNL_DATA_A);
  assign hit_b = (addr_i == ADDR_W'(UNL_ADDR_B)) & (data_i == UNL_DATA_B);

  assign prog_o    = take & (st_q == SQ_PROG);
  assign erase_o   = take & (st_q == SQ_ERS5) & at_a & (data_i == OP_CHIP_ERASE);
  assign lock_o    = take & (st_q == SQ_ERS5) & at_a & (data_i == OP_LOCK);
  assign id_mode_o = id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE;
      id_q <= 1'b0;
    end else if (hard_rst_i) begin
      st_q <= SQ_IDLE;
      id_q <= 1'b0;
    end else if (take) begin
      // default: sequence broken or finished -> array read
      st_q <= SQ_IDLE;
      id_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (hit_a) begin st_q <= SQ_UNL1; id_q <= id_q; end
        SQ_UNL1: if (hit_b) begin st_q <= SQ_UNL2; id_q <= id_q; end
        SQ_UNL2: if (at_a) begin
          unique case (data_i)
            OP_PROGRAM:     st_q <= SQ_PROG;
            OP_ID_ENTER:    id_q <= 1'b1;
            OP_ERASE_SETUP: st_q <= SQ_ERS3;
            default:        ;
          endcase
        end
        SQ_ERS3: if (hit_a) st_q <= SQ_ERS4;
        SQ_ERS4: if (hit_b) st_q <= SQ_ERS5;
        default: ;
      endcase
    end
  end

  // R12
  abort_exits_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> !id_mode_o);
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int          ADDR_W    = 16,
  parameter int          IDX_W     = 6,
  parameter logic [15:0] BOOT_LAST = 16'h1FFF,
  parameter int          ERASE_CYC = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic              lock_i,
  input  logic              hv_i,
  input  logic              abort_i,
  output logic [7:0]        rd_data_o,
  output logic              lock_o,
  output logic              busy_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int CW    = $clog2(ERASE_CYC + 1);

  logic [DEPTH-1:0][7:0] mem_q;
  logic                  lock_q, busy_q;
  logic [CW-1:0]         run_q;
  logic [IDX_W:0]        wk_q;
  logic                  in_boot, blocked, wk_prot;
  logic [IDX_W-1:0]      idx;

  assign in_boot   = addr_i <= ADDR_W'(BOOT_LAST);
  assign idx       = {in_boot, addr_i[IDX_W-2:0]};
  assign blocked   = lock_q & ~hv_i & in_boot;
  assign wk_prot   = lock_q & ~hv_i & wk_q[IDX_W-1];
  assign rd_data_o = mem_q[idx];
  assign lock_o    = lock_q;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q  <= '1;
      lock_q <= 1'b0;
      busy_q <= 1'b0;
      run_q  <= '0;
      wk_q   <= (IDX_W+1)'(DEPTH);
    end else begin
      if (lock_i) lock_q <= 1'b1;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (erase_i) begin
        busy_q <= 1'b1;
        run_q  <= CW'(ERASE_CYC - 1);
        wk_q   <= '0;
      end else if (busy_q) begin
        if (run_q == '0) busy_q <= 1'b0;
        else             run_q  <= run_q - 1'b1;
        if (wk_q != (IDX_W+1)'(DEPTH)) begin
          if (!wk_prot) mem_q[wk_q[IDX_W-1:0]] <= 8'hFF;
          wk_q <= wk_q + 1'b1;
        end
      end
      if (prog_i && !blocked) mem_q[idx] <= mem_q[idx] & data_i;
    end
  end

  // R10
  boot_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_i && blocked) |=> $stable(mem_q));
  // R3
  clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_i |=> ((mem_q & ~$past(mem_q)) == '0));
  // R8
  no_cmd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_i || prog_i || lock_i) |-> !busy_q);
  // R7
  walk_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_q) && !$past(abort_i)) |-> (wk_q == (IDX_W+1)'(DEPTH)));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int          ADDR_W    = 16,
  parameter int          IDX_W     = 6,
  parameter logic [15:0] BOOT_LAST = 16'h1FFF,
  parameter int          ERASE_CYC = 200,
  parameter int          TRP_CYC   = 4,
  parameter int          TRH_CYC   = 3,
  parameter logic [7:0]  MFR_ID    = 8'hDA,
  parameter logic [7:0]  DEV_ID    = 8'h8C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dev_rst_ni,
  input  logic              hv_override_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  logic       wr_stb, rd_start, hard_rst, rd_ok;
  logic       id_mode, prog, erase, lock_set, locked, busy;
  logic [7:0] arr_data, id_val, rd_val;
  logic       tog_q;

  flash_bus_if #(.TRP_CYC(TRP_CYC), .TRH_CYC(TRH_CYC)) u_bus (
    .clk_i, .rst_ni, .dev_rst_ni, .ce_ni, .oe_ni, .we_ni,
    .wr_stb_o(wr_stb), .rd_start_o(rd_start), .hard_rst_o(hard_rst), .rd_ok_o(rd_ok)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .wr_stb_i(wr_stb), .busy_i(busy), .hard_rst_i(hard_rst),
    .addr_i, .data_i, .id_mode_o(id_mode), .prog_o(prog), .erase_o(erase),
    .lock_o(lock_set)
  );

  flash_array #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BOOT_LAST(BOOT_LAST), .ERASE_CYC(ERASE_CYC)
  ) u_arr (
    .clk_i, .rst_ni, .addr_i, .data_i, .prog_i(prog), .erase_i(erase),
    .lock_i(lock_set), .hv_i(hv_override_i), .abort_i(hard_rst),
    .rd_data_o(arr_data), .lock_o(locked), .busy_o(busy)
  );

  always_comb begin
    if      (addr_i == ADDR_W'(0)) id_val = MFR_ID;
    else if (addr_i == ADDR_W'(1)) id_val = DEV_ID;
    else if (addr_i == ADDR_W'(2)) id_val = {7'b0, locked};
    else                           id_val = 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tog_q <= 1'b0;
    else if (rd_start & busy) tog_q <= ~tog_q;
  end

  assign rd_val    = busy ? {1'b0, tog_q, 6'b0} : (id_mode ? id_val : arr_data);
  assign data_oe_o = ~ce_ni & ~oe_ni & rd_ok;
  assign data_o    = data_oe_o ? rd_val : 8'h00;
  assign busy_o    = busy;

  // R1
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!ce_ni && !oe_ni && dev_rst_ni));
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int ERASE_CYC = 200;
  localparam int TRP_CYC   = 4;
  localparam int TRH_CYC   = 3;

  logic clk = 1'b0, rst_ni = 1'b0, dev_rst_ni = 1'b1, hv = 1'b0;
  logic ce_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0, data_o;
  logic        data_oe_o, busy_o;

  int n_chk = 0, n_fail = 0, busy_run = 0, busy_len = 0;
  bit done = 0;
  logic [7:0] nb [32];
  logic [7:0] bt [32];

  always #10 clk = ~clk;

  flash_cmd_seq #(.ERASE_CYC(ERASE_CYC), .TRP_CYC(TRP_CYC), .TRH_CYC(TRH_CYC)) u_flash_cmd_seq (
    .clk_i(clk), .rst_ni, .dev_rst_ni, .hv_override_i(hv), .ce_ni, .oe_ni, .we_ni,
    .addr_i(addr), .data_i(din), .data_o, .data_oe_o, .busy_o
  );

  always @(negedge clk) begin
    if (busy_o) busy_run++;
    else if (busy_run != 0) begin busy_len = busy_run; busy_run = 0; end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); ce_ni = 0; we_ni = 0; addr = a; din = d;
    @(negedge clk); we_ni = 1;
    @(negedge clk); ce_ni = 1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic e);
    @(negedge clk); ce_ni = 0; oe_ni = 0; addr = a;
    @(negedge clk); v = data_o; e = data_oe_o;
    ce_ni = 1; oe_ni = 1;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v; logic e;
    rd(a, v, e);
    chk({req, " oe"}, int'(e), 1);
    chk(req, int'(v), int'(exp));
  endtask

  task automatic cmd3(input logic [7:0] c);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, c);
  endtask

  task automatic cmd6(input logic [7:0] c);
    cmd3(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, c);
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    cmd3(8'hA0); wr(a, d);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2; logic e;
    for (int i = 0; i < 32; i++) begin nb[i] = 8'hFF; bt[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R2 reset state, R1 bus release
    chk("R2 busy", int'(busy_o), 0);
    chk("R1 idle oe", int'(data_oe_o), 0);
    rd_chk("R2 erased", 16'h4003, 8'hFF);
    @(negedge clk); ce_ni = 0; oe_ni = 1; @(negedge clk);
    chk("R1 oe high", int'(data_oe_o), 0);
    ce_ni = 1;

    // R3 program AND
    prog(16'h4003, 8'h5A); nb[3] = 8'h5A;
    rd_chk("R3 prog", 16'h4003, 8'h5A);
    prog(16'h4003, 8'h0F); nb[3] = 8'h0A;
    rd_chk("R3 and", 16'h4003, 8'h0A);

    // R4 identification
    cmd3(8'h90);
    rd_chk("R4 mfr", 16'h0000, 8'hDA);
    rd_chk("R4 dev", 16'h0001, 8'h8C);
    rd_chk("R4 lock0", 16'h0002, 8'h00);
    rd_chk("R4 other", 16'h4003, 8'h00);
    // R5 exits
    cmd3(8'hF0);
    rd_chk("R5 exit3", 16'h4003, nb[3]);
    cmd3(8'h90);
    wr(16'h1234, 8'hF0);
    rd_chk("R5 exit1", 16'h4003, nb[3]);

    // R6 broken sequences
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h77);
    wr(16'h4004, 8'h00);
    rd_chk("R6 bad cmd", 16'h4004, 8'hFF);
    cmd3(8'h90); wr(16'h5555, 8'hAA); wr(16'h4004, 8'h00);
    rd_chk("R6 bad unlock", 16'h4004, 8'hFF);
    rd_chk("R6 id left", 16'h0000, bt[0]);

    // boot writable before lock
    prog(16'h0010, 8'h3C); bt[16] = 8'h3C;
    rd_chk("R10 unlocked", 16'h0010, 8'h3C);

    // R9 lock
    cmd6(8'h40);
    cmd3(8'h90);
    rd_chk("R9 lock bit", 16'h0002, 8'h01);
    wr(16'h0000, 8'hF0);

    // R10 protection
    prog(16'h0010, 8'h00);
    rd_chk("R10 boot kept", 16'h0010, 8'h3C);
    prog(16'h4005, 8'h11); nb[5] = 8'h11;
    rd_chk("R10 other", 16'h4005, 8'h11);

    // R11 override
    hv = 1; prog(16'h0011, 8'h81); bt[17] = 8'h81; hv = 0;
    rd_chk("R11 hv prog", 16'h0011, 8'h81);
    prog(16'h0011, 8'h00);
    rd_chk("R11 relock", 16'h0011, 8'h81);
    cmd3(8'h90);
    rd_chk("R11 lock stays", 16'h0002, 8'h01);
    wr(16'h0000, 8'hF0);

    // R7 erase with lock, R8 busy behaviour
    cmd6(8'h10);
    chk("R7 busy", int'(busy_o), 1);
    rd(16'h4003, v, e); rd(16'h4003, v2, e);
    chk("R8 toggle", int'(v[6] ^ v2[6]), 1);
    chk("R8 status bits", int'({v[7], v[5:0], v2[7], v2[5:0]}), 0);
    cmd3(8'h90);
    wait_idle();
    chk("R7 busy len", busy_len, ERASE_CYC);
    for (int i = 0; i < 32; i++) nb[i] = 8'hFF;
    rd_chk("R8 ignored", 16'h4003, 8'hFF);
    rd_chk("R7 erased", 16'h4005, 8'hFF);
    rd_chk("R10 boot erase", 16'h0010, 8'h3C);
    rd_chk("R10 boot erase2", 16'h0011, 8'h81);

    // R11 erase under override
    hv = 1; cmd6(8'h10); wait_idle(); hv = 0;
    for (int i = 0; i < 32; i++) bt[i] = 8'hFF;
    rd_chk("R11 hv erase", 16'h0010, 8'hFF);

    // R12 short pulse keeps id mode
    cmd3(8'h90);
    @(negedge clk); dev_rst_ni = 0; ce_ni = 0; oe_ni = 0;
    @(negedge clk); chk("R12 float", int'(data_oe_o), 0);
    dev_rst_ni = 1; ce_ni = 1; oe_ni = 1;
    repeat (TRH_CYC + 2) @(negedge clk);
    rd_chk("R12 short", 16'h0000, 8'hDA);

    // R12 long pulse, R13 recovery
    @(negedge clk); dev_rst_ni = 0; ce_ni = 0; oe_ni = 0; addr = 16'h0000;
    repeat (TRP_CYC + 2) @(negedge clk);
    chk("R12 float long", int'(data_oe_o), 0);
    dev_rst_ni = 1;
    repeat (TRH_CYC - 1) @(posedge clk);
    @(negedge clk); chk("R13 blocked", int'(data_oe_o), 0);
    @(posedge clk);
    @(negedge clk); chk("R13 open", int'(data_oe_o), 1);
    chk("R12 array mode", int'(data_o), int'(bt[0]));
    ce_ni = 1; oe_ni = 1;

    // R12 abort erase
    prog(16'h4006, 8'h12);
    cmd6(8'h10);
    repeat (5) @(negedge clk);
    dev_rst_ni = 0;
    repeat (TRP_CYC + 1) @(negedge clk);
    chk("R12 abort", int'(busy_o), 0);
    dev_rst_ni = 1;
    repeat (TRH_CYC + 2) @(negedge clk);
    hv = 1; cmd6(8'h10); wait_idle(); hv = 0;
    for (int i = 0; i < 32; i++) begin nb[i] = 8'hFF; bt[i] = 8'hFF; end

    // random programs and broken sequences above the boot region
    void'($urandom(32'h1F2E3D4C));
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r;
      logic [15:0] a;
      r = $urandom;
      a = 16'h4000 | 16'(r[4:0]);
      if (r[20]) begin
        wr(16'h5555, 8'hAA); wr(a, r[15:8]);
        rd_chk("R6 rand", a, nb[r[4:0]]);
      end else begin
        prog(a, r[15:8]);
        nb[r[4:0]] = nb[r[4:0]] & r[15:8];
        rd_chk("R3 rand", a, nb[r[4:0]]);
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule